// File: doc/BRIEF.md
# Multicast hash table filter

This block tells the receive path whether a multicast destination address falls into a 4096-bit hash table kept by software. For every address presented with a valid strobe it extracts a 12-bit index from one of four selectable bit windows of the upper two address bytes. It then looks that index up in a table folded into 128 words of 32 bits and returns a registered one-cycle match result.

A host register port gives word-wide write and read access to the table and to a small control word. The control word holds a filter enable bit and a 2-bit window selector. Software rebuilds the table by clearing every word and then setting one bit per wanted group address. Frame parsing, CRC checking and the final accept or drop decision are left to neighbouring logic.

Address byte k of the destination occupies `addr_i[8k+7:8k]`. Byte 0 is the first byte on the wire, so the group bit is `addr_i[0]`.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset `match_valid_o`, `match_o` and `host_rdata_o` are 0, every table word reads 0, and the control word reads 0 (filter disabled, window selector 0).
- R2: `match_valid_o` is 1 in the cycle after `addr_valid_i` was 1 and 0 otherwise; `match_o` is never 1 while `match_valid_o` is 0.
- R3: With window selector 0 the lookup index is `addr_i[47:36]`.
- R4: With window selector 1 the lookup index is `addr_i[46:35]`.
- R5: With window selector 2 the lookup index is `addr_i[45:34]`.
- R6: With window selector 3 the lookup index is `addr_i[43:32]`.
- R7: Index bits 11:5 select the table word and index bits 4:0 select the bit within that word. The result is `match_o` = 1 exactly when that bit is set, the filter is enabled and the address is a group address.
- R8: While the enable bit (control bit 0) is 0, `match_o` stays 0 whatever the table holds.
- R9: An address with `addr_i[0]` = 0 (unicast) always gives `match_o` = 0.
- R10: Host address 0..127 writes or reads table word n. Host address 128 is the control word: bit 0 is enable, bits 6:5 are the window selector, and the other bits read 0. Host addresses 129..255 ignore writes and read 0. Read data appears one cycle after the request and shows the contents before any write made in that same cycle. A control write applies to lookups presented from the next cycle onward.
- R11: A table write and a lookup of the same word in the same cycle are resolved with the write first, so the lookup sees the newly written word.
- R12: After all 128 words are written to 0, no address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_valid_i | input | 1 | Destination address strobe |
| addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 8 | Host register address (0..127 table, 128 control) |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, one cycle after the address |
| match_valid_o | output | 1 | Lookup result valid |
| match_o | output | 1 | Lookup hit |

## Verification
A host table write and a lookup can land on the same table word in the same cycle. The bench provokes this by presenting a lookup whose index falls in the word being written, once to set the matching bit and once to clear it. Its behavioural model applies the write before evaluating the lookup, so a hit after a set and a miss after a clear prove the forwarding. The random sweep mixes host writes and lookups freely, so further collisions arise and are judged by the same model on every clock.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  typedef struct packed {
    logic       en;
    logic [1:0] win;
  } mcf_ctl_t;

  // right shift of each index window below the topmost one
  function automatic int win_shift(input int m);
    case (m)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/mcf_index.sv
module mcf_index #(
  parameter int IDX_W = 12,
  localparam int HI_W = IDX_W + 4
) (
  input  logic [HI_W-1:0]  hi_i,
  input  logic [1:0]       win_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] cand [4];

  for (genvar m = 0; m < 4; m++) begin : g_win
    localparam int LSB = HI_W - IDX_W - mcf_pkg::win_shift(m);
    assign cand[m] = hi_i[LSB +: IDX_W];
  end

  assign idx_o = cand[win_i];
endmodule

// File: rtl/mcf_table.sv
module mcf_table #(
  parameter int IDX_W  = 12,
  parameter int WORD_W = 32,
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int WSEL_W    = IDX_W - BIT_W,
  localparam int NUM_WORDS = 1 << WSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WSEL_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WSEL_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic              hit_o
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];
  logic [WSEL_W-1:0] lk_word;
  logic [BIT_W-1:0]  lk_bit;
  logic [WORD_W-1:0] lk_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  assign lk_word = lk_idx_i[IDX_W-1:BIT_W];
  assign lk_bit  = lk_idx_i[BIT_W-1:0];
  // same-cycle write wins over stored word
  assign lk_data = (we_i && waddr_i == lk_word) ? wdata_i : mem_q[lk_word];
  assign hit_o   = lk_data[lk_bit];

  a_r10_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/mcf_ctl.sv
module mcf_ctl (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             en_i,
  input  logic [1:0]       win_i,
  output mcf_pkg::mcf_ctl_t ctl_o
);
  mcf_pkg::mcf_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= '{en: en_i, win: win_i};
  end

  assign ctl_o = ctl_q;

  a_r10_ctl_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_q));
endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 12,
  parameter int WORD_W = 32,
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int WSEL_W    = IDX_W - BIT_W,
  localparam int HOST_AW   = WSEL_W + 1,
  localparam int HI_W      = IDX_W + 4,
  localparam int NUM_WORDS = 1 << WSEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               addr_valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [WORD_W-1:0]  host_wdata_i,
  output logic [WORD_W-1:0]  host_rdata_o,
  output logic               match_valid_o,
  output logic               match_o
);
  mcf_pkg::mcf_ctl_t ctl;
  logic              sel_tbl, sel_ctl;
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [WORD_W-1:0] tbl_rd, ctl_rd;
  logic              unused_bits;

  assign sel_tbl = !host_addr_i[HOST_AW-1];
  assign sel_ctl = host_addr_i == HOST_AW'(NUM_WORDS);
  assign unused_bits = ^{addr_i[ADDR_W-HI_W-1:1], host_wdata_i[WORD_W-1:7], host_wdata_i[4:1]};

  mcf_ctl u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (host_we_i && sel_ctl),
    .en_i   (host_wdata_i[0]),
    .win_i  (host_wdata_i[6:5]),
    .ctl_o  (ctl)
  );

  mcf_index #(.IDX_W(IDX_W)) u_index (
    .hi_i  (addr_i[ADDR_W-1 -: HI_W]),
    .win_i (ctl.win),
    .idx_o (idx)
  );

  mcf_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (host_we_i && sel_tbl),
    .waddr_i  (host_addr_i[WSEL_W-1:0]),
    .wdata_i  (host_wdata_i),
    .raddr_i  (host_addr_i[WSEL_W-1:0]),
    .rdata_o  (tbl_rd),
    .lk_idx_i (idx),
    .hit_o    (hit)
  );

  always_comb begin
    ctl_rd      = '0;
    ctl_rd[0]   = ctl.en;
    ctl_rd[6:5] = ctl.win;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rdata_o  <= '0;
      match_valid_o <= 1'b0;
      match_o       <= 1'b0;
    end else begin
      host_rdata_o  <= sel_tbl ? tbl_rd : (sel_ctl ? ctl_rd : '0);
      match_valid_o <= addr_valid_i;
      match_o       <= addr_valid_i && ctl.en && addr_i[0] && hit;
    end
  end

  a_r2_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i |=> match_valid_o);
  a_r2_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> !match_valid_o);
  a_r2_match_implies_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> match_valid_o);
  a_r8_off_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.en |=> !match_o);
  a_r9_unicast_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && !addr_i[0]) |=> !match_o);
endmodule

// File: tb/mc_hash_filter_bench.sv
module mc_hash_filter_bench;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        addr_valid_i = 0;
  logic [47:0] addr_i = '0;
  logic        host_we_i = 0;
  logic [7:0]  host_addr_i = '0;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o;
  logic        match_valid_o, match_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_tbl [128];
  logic        m_en = 0;
  logic [1:0]  m_win = 0;

  always #10 clk_i = ~clk_i;

  mc_hash_filter u_mc_hash_filter (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [47:0] a, input logic [1:0] w);
    case (w)
      2'd0: return int'((a >> 36) & 48'hfff);
      2'd1: return int'((a >> 35) & 48'hfff);
      2'd2: return int'((a >> 34) & 48'hfff);
      default: return int'((a >> 32) & 48'hfff);
    endcase
  endfunction

  function automatic logic [47:0] mk_addr(input int idx, input logic [1:0] w, input logic grp);
    logic [47:0] a;
    int sh;
    a = {$urandom, $urandom};
    sh = (w == 0) ? 36 : (w == 1) ? 35 : (w == 2) ? 34 : 32;
    for (int b = 0; b < 12; b++) a[sh + b] = idx[b];
    a[0] = grp;
    return a;
  endfunction

  // one clock: drive, predict, sample at the following falling edge
  task automatic cyc(input logic v, input logic [47:0] a, input logic we,
                     input logic [7:0] ha, input logic [31:0] wd, input string tag);
    logic [31:0] exp_rd;
    logic        exp_m;
    int          ix;
    exp_rd = (ha < 128) ? m_tbl[ha] : (ha == 128) ? {25'd0, m_win, 4'd0, m_en} : 32'd0;
    if (we && ha < 128) m_tbl[ha] = wd;
    ix = idx_of(a, m_win);
    exp_m = v && m_en && a[0] && m_tbl[ix / 32][ix % 32];
    if (we && ha == 128) begin m_en = wd[0]; m_win = wd[6:5]; end
    addr_valid_i = v; addr_i = a; host_we_i = we; host_addr_i = ha; host_wdata_i = wd;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag, "match_valid", {31'd0, match_valid_o}, {31'd0, v});
    chk(tag, "match", {31'd0, match_o}, {31'd0, exp_m});
    chk(tag, "rdata", host_rdata_o, exp_rd);
  endtask

  task automatic hw(input logic [7:0] ha, input logic [31:0] wd, input string tag);
    cyc(0, '0, 1, ha, wd, tag);
  endtask

  task automatic look(input logic [47:0] a, input string tag);
    cyc(1, a, 0, 8'd0, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string wtag [4] = '{"R3", "R4", "R5", "R6"};
    for (int i = 0; i < 128; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R1", "reset match_valid", {31'd0, match_valid_o}, 32'd0);
    chk("R1", "reset match", {31'd0, match_o}, 32'd0);
    chk("R1", "reset rdata", host_rdata_o, 32'd0);
    rst_ni = 1;
    cyc(0, '0, 0, 8'd128, '0, "R1");
    cyc(0, '0, 0, 8'd77, '0, "R1");

    // R10 control layout and readback
    hw(8'd128, 32'hffff_ffff, "R10");
    cyc(0, '0, 0, 8'd128, '0, "R10");
    hw(8'd200, 32'hdead_beef, "R10");
    cyc(0, '0, 0, 8'd200, '0, "R10");
    hw(8'd9, 32'h1234_5678, "R10");
    cyc(0, '0, 0, 8'd9, '0, "R10");
    hw(8'd9, 32'h0, "R10");

    // R3..R6 each window, hit and neighbour miss
    for (int w = 0; w < 4; w++) begin
      int ix;
      ix = 12'h5a3 + w * 37;
      hw(8'd128, {25'd0, 2'(w), 4'd0, 1'b1}, wtag[w]);
      hw(8'(ix / 32), 32'd1 << (ix % 32), wtag[w]);
      look(mk_addr(ix, 2'(w), 1), wtag[w]);
      look(mk_addr(ix ^ 1, 2'(w), 1), wtag[w]);
      look(mk_addr(ix ^ 12'h800, 2'(w), 1), wtag[w]);
      hw(8'(ix / 32), 32'd0, wtag[w]);
    end

    // R7 corner bits
    hw(8'd128, 32'h1, "R7");
    hw(8'd127, 32'h8000_0000, "R7");
    hw(8'd0, 32'h1, "R7");
    look(mk_addr(12'hfff, 0, 1), "R7");
    look(mk_addr(12'hfe0, 0, 1), "R7");
    look(mk_addr(12'h000, 0, 1), "R7");
    look(mk_addr(12'h001, 0, 1), "R7");

    // R9 unicast never hits
    look(mk_addr(12'hfff, 0, 0), "R9");
    look(mk_addr(12'h000, 0, 0), "R9");

    // R8 disabled filter
    hw(8'd128, 32'h0, "R8");
    look(mk_addr(12'hfff, 0, 1), "R8");
    look(mk_addr(12'h000, 0, 1), "R8");
    hw(8'd128, 32'h1, "R8");

    // R11 write and lookup of the same word together
    cyc(1, mk_addr(20 * 32 + 3, 0, 1), 1, 8'd20, 32'h8, "R11");
    look(mk_addr(20 * 32 + 3, 0, 1), "R11");
    cyc(1, mk_addr(12'h000, 0, 1), 1, 8'd0, 32'h0, "R11");
    cyc(1, mk_addr(12'hfff, 0, 1), 1, 8'd126, 32'hffff_ffff, "R11");

    // R2 idle cycles
    cyc(0, mk_addr(12'hfff, 0, 1), 0, 8'd0, '0, "R2");
    look(mk_addr(12'hfff, 0, 1), "R2");

    // mixed random traffic across windows, collisions included
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  ha;
      logic        we;
      logic [31:0] wd;
      we = ($urandom % 3) == 0;
      ha = ($urandom % 16 == 0) ? 8'd128 : 8'($urandom % 128);
      wd = (ha == 128) ? {25'd0, 2'($urandom), 4'd0, 1'($urandom % 4 != 0)} : $urandom;
      cyc(1'($urandom % 4 != 0), {$urandom, $urandom}, we, ha, wd, "R7");
    end

    // R12 rebuild: clear every word, then nothing hits
    hw(8'd128, 32'h1, "R12");
    for (int i = 0; i < 128; i++) hw(8'(i), 32'h0, "R12");
    for (int n = 0; n < 64; n++) look({$urandom, $urandom} | 48'h1, "R12");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule